// File: doc/BRIEF.md
# Multidrop Nine-Bit Address Filter

This block sits between a UART receiver and its receive FIFO on a shared multidrop serial bus where every character carries a ninth bit. A character whose ninth bit is 1 names a destination; a character whose ninth bit is 0 carries payload. Each character is compared with two node addresses: a unicast address that no other node on the bus holds, and a group address that several nodes may hold. A hit on either one selects the node. While the node is selected, payload characters are passed on to the FIFO. An address character that hits neither address deselects the node.

A mode input chooses how the filter behaves. In the keep mode (code 3) the filter runs and the address character that selected the node is passed to the FIFO as well. In the drop mode (code 4) the filter runs and that address character is discarded. With any other code the filter is bypassed: every character goes through and the node is left unselected. The outputs are registered. They appear one clock after the receiver's valid strobe, as a strobe that tells the FIFO to accept, a copy of the character and a one-cycle address-match pulse.

Top module: `mdrop_addr_filter`

## Requirements
- R1: After reset, acc_valid and addr_match are 0 and the node is unselected, so payload characters (ninth bit 0) are dropped until an address character hits.
- R2: Only a character with rx_addr_flag = 1 is treated as an address. A payload character never raises addr_match and never changes whether the node is selected.
- R3: In code 3 or code 4, an address character equal to ucast_addr raises addr_match for exactly one cycle and selects the node.
- R4: In code 3 or code 4, an address character equal to mcast_addr raises addr_match for exactly one cycle and selects the node.
- R5: In code 3 or code 4, an address character that equals neither register raises no addr_match and deselects the node, so the payload characters that follow are dropped.
- R6: While the node is selected, every payload character is accepted: acc_valid = 1 and acc_data equals the character.
- R7: In code 3, the address character that hits is itself accepted, with acc_data equal to that address.
- R8: In code 4, the address character that hits is not accepted (acc_valid stays 0), although addr_match still pulses.
- R9: With a mode code other than 3 or 4, every valid character is accepted regardless of its ninth bit, addr_match stays 0, and the node is left unselected.
- R10: Outputs are registered one cycle after the valid strobe. Without rx_valid there is no accept and no match in the next cycle.
- R11: When ucast_addr equals mcast_addr, a hit gives a single one-cycle pulse, as it does for a distinct address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | DATA_W | Received character |
| rx_addr_flag | input | 1 | Ninth bit; 1 marks an address character |
| ucast_addr | input | DATA_W | Unicast address of this node |
| mcast_addr | input | DATA_W | Group address shared with other nodes |
| filt_mode | input | MODE_W | Mode code: 3 keep, 4 drop, other bypass |
| acc_valid | output | 1 | Accept strobe for the receive FIFO |
| acc_data | output | DATA_W | Character to write into the FIFO |
| addr_match | output | 1 | One-cycle pulse on an address hit |

## Verification
The bench builds the block with its default eight-bit characters and three-bit mode code. At that width every possible address value can be swept against fixed unicast and group registers, each address followed by a payload character. This shows that only the two programmed values select the node and that all 254 others deselect it. The bench also covers the mode switches between bypass, keep and drop, the case of equal unicast and group addresses, and back-to-back characters with no idle cycles between them.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;

    typedef enum logic [1:0] {
        FILT_BYPASS = 2'd0,
        FILT_KEEP   = 2'd1,
        FILT_DROP   = 2'd2
    } filt_mode_e;

    typedef struct packed {
        logic accept;
        logic hit;
        logic sel_load;
        logic sel_next;
    } filt_dec_t;

    function automatic filt_dec_t filt_decide(
        input filt_mode_e mode,
        input logic       is_addr,
        input logic       addr_hit,
        input logic       selected
    );
        filt_dec_t d;
        d = '0;
        case (mode)
            FILT_KEEP, FILT_DROP: begin
                if (is_addr) begin
                    d.hit      = addr_hit;
                    d.sel_load = 1'b1;
                    d.sel_next = addr_hit;
                    d.accept   = addr_hit && (mode == FILT_KEEP);
                end else begin
                    d.accept   = selected;
                end
            end
            default: begin
                d.accept   = 1'b1;
                d.sel_load = 1'b1;
                d.sel_next = 1'b0;
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mdrop_mode_dec.sv
module mdrop_mode_dec
    import mdrop_pkg::*;
#(
    parameter int MODE_W    = 3,
    parameter int KEEP_CODE = 3,
    parameter int DROP_CODE = 4
) (
    input  logic [MODE_W-1:0] code_i,
    output filt_mode_e        mode_o
);
    localparam logic [MODE_W-1:0] KEEP_V = MODE_W'(KEEP_CODE);
    localparam logic [MODE_W-1:0] DROP_V = MODE_W'(DROP_CODE);

    always_comb begin
        if (code_i == KEEP_V)      mode_o = FILT_KEEP;
        else if (code_i == DROP_V) mode_o = FILT_DROP;
        else                       mode_o = FILT_BYPASS;
    end
endmodule

// File: rtl/mdrop_addr_cmp.sv
module mdrop_addr_cmp #(
    parameter int DATA_W  = 8,
    parameter int NUM_REF = 2
) (
    input  logic [DATA_W-1:0]              char_i,
    input  logic [NUM_REF-1:0][DATA_W-1:0] refs_i,
    output logic                           hit_o
);
    logic [NUM_REF-1:0] eq;

    for (genvar i = 0; i < NUM_REF; i++) begin : g_ref
        assign eq[i] = (char_i == refs_i[i]);
    end

    assign hit_o = |eq;
endmodule

// File: rtl/mdrop_sel_reg.sv
module mdrop_sel_reg
    import mdrop_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      valid_i,
    input  filt_dec_t dec_i,
    output logic      sel_o
);
    always_ff @(posedge clk) begin
        if (rst)
            sel_o <= 1'b0;
        else if (valid_i && dec_i.sel_load)
            sel_o <= dec_i.sel_next;
    end
endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter
    import mdrop_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int MODE_W    = 3,
    parameter int KEEP_CODE = 3,
    parameter int DROP_CODE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_addr_flag,
    input  logic [DATA_W-1:0] ucast_addr,
    input  logic [DATA_W-1:0] mcast_addr,
    input  logic [MODE_W-1:0] filt_mode,
    output logic              acc_valid,
    output logic [DATA_W-1:0] acc_data,
    output logic              addr_match
);
    localparam int NUM_REF = 2;

    filt_mode_e                 mode;
    logic [NUM_REF-1:0][DATA_W-1:0] refs;
    logic                       hit;
    logic                       selected;
    filt_dec_t                  dec;

    assign refs[0] = ucast_addr;
    assign refs[1] = mcast_addr;

    mdrop_mode_dec #(
        .MODE_W(MODE_W), .KEEP_CODE(KEEP_CODE), .DROP_CODE(DROP_CODE)
    ) u_mode (
        .code_i(filt_mode),
        .mode_o(mode)
    );

    mdrop_addr_cmp #(.DATA_W(DATA_W), .NUM_REF(NUM_REF)) u_cmp (
        .char_i(rx_data),
        .refs_i(refs),
        .hit_o (hit)
    );

    assign dec = filt_decide(mode, rx_addr_flag, hit, selected);

    mdrop_sel_reg u_sel (
        .clk    (clk),
        .rst    (rst),
        .valid_i(rx_valid),
        .dec_i  (dec),
        .sel_o  (selected)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_valid  <= 1'b0;
            addr_match <= 1'b0;
            acc_data   <= '0;
        end else begin
            acc_valid  <= rx_valid && dec.accept;
            addr_match <= rx_valid && dec.hit;
            if (rx_valid)
                acc_data <= rx_data;
        end
    end
endmodule

// File: rtl/mdrop_addr_filter_chk.sv
module mdrop_addr_filter_chk #(
    parameter int DATA_W    = 8,
    parameter int MODE_W    = 3,
    parameter int KEEP_CODE = 3,
    parameter int DROP_CODE = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_addr_flag,
    input logic [DATA_W-1:0] ucast_addr,
    input logic [DATA_W-1:0] mcast_addr,
    input logic [MODE_W-1:0] filt_mode,
    input logic              acc_valid,
    input logic [DATA_W-1:0] acc_data,
    input logic              addr_match
);
    localparam logic [MODE_W-1:0] KV = MODE_W'(KEEP_CODE);
    localparam logic [MODE_W-1:0] DV = MODE_W'(DROP_CODE);

    logic filt_on;
    assign filt_on = (filt_mode == KV) || (filt_mode == DV);

    a_r2_payload_no_match: assert property (@(posedge clk) disable iff (rst)
        rx_valid && !rx_addr_flag |=> !addr_match);

    a_r3_ucast_hit: assert property (@(posedge clk) disable iff (rst)
        rx_valid && rx_addr_flag && filt_on && rx_data == ucast_addr |=> addr_match);

    a_r4_mcast_hit: assert property (@(posedge clk) disable iff (rst)
        rx_valid && rx_addr_flag && filt_on && rx_data == mcast_addr |=> addr_match);

    a_r5_miss_no_pulse: assert property (@(posedge clk) disable iff (rst)
        rx_valid && rx_addr_flag && rx_data != ucast_addr && rx_data != mcast_addr
        |=> !addr_match);

    a_r8_drop_addr: assert property (@(posedge clk) disable iff (rst)
        rx_valid && rx_addr_flag && filt_mode == DV |=> !acc_valid);

    a_r7_keep_addr: assert property (@(posedge clk) disable iff (rst)
        rx_valid && rx_addr_flag && filt_mode == KV && rx_data == ucast_addr
        |=> acc_valid && acc_data == $past(rx_data));

    a_r9_bypass_accept: assert property (@(posedge clk) disable iff (rst)
        rx_valid && !filt_on |=> acc_valid && !addr_match);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> !acc_valid && !addr_match);
endmodule

bind mdrop_addr_filter mdrop_addr_filter_chk #(
    .DATA_W(DATA_W), .MODE_W(MODE_W), .KEEP_CODE(KEEP_CODE), .DROP_CODE(DROP_CODE)
) u_chk (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_addr_flag(rx_addr_flag), .ucast_addr(ucast_addr), .mcast_addr(mcast_addr),
    .filt_mode(filt_mode), .acc_valid(acc_valid), .acc_data(acc_data),
    .addr_match(addr_match)
);

// File: tb/mdrop_addr_filter_test.sv
module mdrop_addr_filter_test;
    localparam int DW = 8;
    localparam int MW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rx_valid = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic          rx_addr_flag = 1'b0;
    logic [DW-1:0] ucast_addr = 8'h21;
    logic [DW-1:0] mcast_addr = 8'hF0;
    logic [MW-1:0] filt_mode = 3'd4;
    logic          acc_valid;
    logic [DW-1:0] acc_data;
    logic          addr_match;

    mdrop_addr_filter #(.DATA_W(DW), .MODE_W(MW)) uut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_addr_flag(rx_addr_flag), .ucast_addr(ucast_addr), .mcast_addr(mcast_addr),
        .filt_mode(filt_mode), .acc_valid(acc_valid), .acc_data(acc_data),
        .addr_match(addr_match)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic          v;
        logic [DW-1:0] d;
        logic          m;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   errors = 0;
    int   checks = 0;
    logic m_sel = 1'b0;
    bit   done = 1'b0;

    // one cycle: drive at negedge, predict from the requirements, push
    task automatic step(input logic v, input logic a, input logic [DW-1:0] d,
                        input logic [MW-1:0] md, input string tag);
        exp_t e;
        logic hit;
        @(negedge clk);
        rx_valid = v; rx_addr_flag = a; rx_data = d; filt_mode = md;
        e.v = 1'b0; e.m = 1'b0; e.d = d; e.tag = tag;
        hit = (d == ucast_addr) || (d == mcast_addr);
        if (v) begin
            if (md != 3'd3 && md != 3'd4) begin
                e.v = 1'b1; m_sel = 1'b0;
            end else if (a) begin
                e.m = hit; e.v = hit && (md == 3'd3); m_sel = hit;
            end else begin
                e.v = m_sel;
            end
        end
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, 8'h00, filt_mode, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (acc_valid !== e.v || addr_match !== e.m ||
                    (e.v && acc_data !== e.d)) begin
                    errors++;
                    $display("FAIL %s: got v=%b m=%b d=%h, expected v=%b m=%b d=%h",
                             e.tag, acc_valid, addr_match, acc_data, e.v, e.m, e.d);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if (acc_valid !== 1'b0 || addr_match !== 1'b0) begin
            errors++;
            $display("FAIL R1: got v=%b m=%b, expected v=0 m=0", acc_valid, addr_match);
        end
        // R1: payload dropped while unselected
        step(1, 0, 8'h55, 3'd4, "R1 unselected drop");
        step(1, 0, 8'h56, 3'd4, "R1 unselected drop");
        // R3 unicast hit in drop mode, R8 address dropped
        step(1, 1, 8'h21, 3'd4, "R3/R8 ucast hit drop");
        step(1, 0, 8'hA1, 3'd4, "R6 payload after hit");
        step(1, 0, 8'hA2, 3'd4, "R6 back-to-back payload");
        idle("R10 idle");
        step(1, 0, 8'hA3, 3'd4, "R2 payload keeps selection");
        // R5 miss deselects
        step(1, 1, 8'h22, 3'd4, "R5 miss");
        step(1, 0, 8'hB0, 3'd4, "R5 dropped after miss");
        // R4 multicast hit, keep mode R7
        step(1, 1, 8'hF0, 3'd3, "R4/R7 mcast hit keep");
        step(1, 0, 8'hB1, 3'd3, "R6 payload in keep");
        step(1, 1, 8'h21, 3'd3, "R3/R7 ucast hit keep");
        step(1, 1, 8'h99, 3'd3, "R5 miss in keep");
        step(1, 0, 8'hB2, 3'd3, "R5 drop in keep");
        // R2: payload equal to address value gives no match
        step(1, 0, 8'h21, 3'd3, "R2 payload equal to ucast");
        idle("R10 idle");
        // R9 bypass
        step(1, 1, 8'h21, 3'd4, "R3 select before bypass");
        step(1, 1, 8'h21, 3'd0, "R9 bypass addr");
        step(1, 0, 8'h33, 3'd7, "R9 bypass payload");
        step(1, 1, 8'h44, 3'd2, "R9 bypass other addr");
        step(1, 0, 8'h34, 3'd4, "R9 unselected after bypass");
        idle("R10 idle");
        // R11 equal addresses
        @(negedge clk); mcast_addr = 8'h21;
        step(1, 1, 8'h21, 3'd4, "R11 equal addrs hit");
        idle("R11 single pulse");
        step(1, 0, 8'h61, 3'd4, "R11 payload accepted");
        @(negedge clk); mcast_addr = 8'hF0;
        // sweep every address value, R3/R4/R5
        for (int i = 0; i < 256; i++) begin
            step(1, 1, 8'(i), 3'd4, "R3/R4/R5 sweep addr");
            step(1, 0, 8'(255 - i), 3'd4, "R5/R6 sweep payload");
        end
        // reset mid-selection, R1
        step(1, 1, 8'hF0, 3'd3, "R4 select before reset");
        idle("R10 idle");
        wait (q.size() == 0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; m_sel = 1'b0;
        step(1, 0, 8'h77, 3'd3, "R1 dropped after reset");
        idle("R10 idle");
        wait (q.size() == 0);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule